// File: doc/BRIEF.md
# Loopback-Handshake Bus Master Sequencer

This block is the user-side controller for a bus-master port whose data phase comes back through a local slave port. A single-beat write or read starts from an active-low push button. The block holds a fixed target address and all-ones byte enables. It waits a settling interval and then raises the matching master request. It answers the local strobe that the bus side raises during the data phase, and it keeps the request high until the master-level completion arrives.

The local strobes run in the opposite direction to the master operation. During a master read, the returned data arrives as a local *write* strobe. The block latches the data and acknowledges it. During a master write, the bus side fetches the outgoing data with a local *read* strobe, and the block acknowledges that strobe.

After a read, the low nibble of the returned word is compared with the nibble last written. The result is shown as a pass or fail code on a 4-bit status output. A third button (clear) returns the block from either done state to idle.

FSM states and transitions (status code in brackets):
- **IDLE** [0]: on write button → **W_SETTLE**; otherwise on read button → **R_SETTLE**.
- **W_SETTLE** [1]: after SETTLE_CYC cycles → **W_REQ**.
- **W_REQ** [2]: on qualified local read strobe → **W_ACK**.
- **W_ACK** [3]: on write-done → **W_DONE**; otherwise → **W_WAIT**.
- **W_WAIT** [3]: on write-done → **W_DONE**.
- **W_DONE** [4]: on clear → **IDLE**.
- **R_SETTLE** [8]: after SETTLE_CYC cycles → **R_REQ**.
- **R_REQ** [9]: on qualified local write strobe → **R_ACK**.
- **R_ACK** [A]: on read-done → **R_DONE**; otherwise → **R_WAIT**.
- **R_WAIT** [A]: on read-done → **R_DONE**.
- **R_DONE** [B on match, C on mismatch]: on clear → **IDLE**.

Top module: `bus_loop_seq`

## Requirements
- R1: Synchronous reset puts the block in IDLE. Both master requests and both local acknowledges are low, the status is 0x0, and the remembered write nibble and the captured read word are zero.
- R2: In IDLE, a low on the write button stores the write-value input and enters W_SETTLE (status 0x1). The block stays there for exactly SETTLE_CYC cycles and then raises the write request in W_REQ (status 0x2).
- R3: While the write request is high in W_REQ, a qualified local read strobe causes a local read acknowledge. The acknowledge is high for exactly one cycle, starting the cycle after the strobe, and the status is then 0x3. The outgoing data is the stored nibble in bits 3:0, with all upper bits zero.
- R4: The write request stays high until write-done is seen in W_ACK or W_WAIT. It is low from the next cycle, in W_DONE (status 0x4).
- R5: In IDLE with the write button high, a low on the read button enters R_SETTLE (status 0x8) for exactly SETTLE_CYC cycles. The block then raises the read request in R_REQ (status 0x9).
- R6: In R_REQ, a qualified local write strobe latches the full returned word on that same clock edge. It also causes a one-cycle local write acknowledge on the next cycle (status 0xA). A strobe in any other state is ignored: no acknowledge and no capture.
- R7: The read request stays high until read-done is seen in R_ACK or R_WAIT. It is low from the next cycle.
- R8: In R_DONE, the status is 0xB when bits 3:0 of the captured word equal the stored write nibble, and 0xC otherwise.
- R9: Start buttons are ignored in every state except IDLE. From W_DONE or R_DONE, a low on the clear button returns to IDLE; clear is ignored in all other states.
- R10: The address output always equals TARGET_ADDR, and every byte-enable lane is high.
- R11: With USE_CE=1, a strobe counts only when bit CE_SEL of its chip-enable vector is high. With USE_CE=0, the chip-enable vector is not looked at.
- R12: If both start buttons are low together in IDLE, the write starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_wr_n | input | 1 | Start-write button, active low |
| btn_rd_n | input | 1 | Start-read button, active low |
| btn_clr_n | input | 1 | Return-to-idle button, active low |
| wr_value | input | NIB_W | Nibble to be written |
| mst_rd_req | output | 1 | Master read request |
| mst_wr_req | output | 1 | Master write request |
| mst_addr | output | AW | Fixed target address |
| mst_be | output | BE_LANES | Byte enables, all ones |
| mst_rd_done | input | 1 | Master read complete |
| mst_wr_done | input | 1 | Master write complete |
| loc_wr_stb | input | 1 | Local write strobe (read data return) |
| loc_wr_ce | input | CE_W | Chip enables for the local write strobe |
| loc_din | input | DW | Returned read data |
| loc_wr_ack | output | 1 | Local write acknowledge |
| loc_rd_stb | input | 1 | Local read strobe (write data fetch) |
| loc_rd_ce | input | CE_W | Chip enables for the local read strobe |
| loc_dout | output | DW | Outgoing write data |
| loc_rd_ack | output | 1 | Local read acknowledge |
| rd_data | output | DW | Captured read word |
| status | output | 4 | State and result code |

## Verification
The bench builds the block with SETTLE_CYC=10, a 32-bit data path, eight byte lanes, and USE_CE=1 with CE_SEL=1 on a 4-bit chip-enable vector. These settings make the full ten-cycle settling window observable. Turning on chip-enable qualification lets a strobe with the wrong enable bit be shown to have no effect. The scenarios also cover a completion arriving in the very cycle of the local acknowledge, a stray strobe while idle, both buttons pressed together, and a reset in the middle of a transaction.

// File: rtl/bus_loop_pkg.sv
package bus_loop_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_SETTLE,
        ST_W_REQ,
        ST_W_ACK,
        ST_W_WAIT,
        ST_W_DONE,
        ST_R_SETTLE,
        ST_R_REQ,
        ST_R_ACK,
        ST_R_WAIT,
        ST_R_DONE
    } seq_state_t;

    localparam logic [3:0] CODE_IDLE     = 4'h0;
    localparam logic [3:0] CODE_W_SETTLE = 4'h1;
    localparam logic [3:0] CODE_W_REQ    = 4'h2;
    localparam logic [3:0] CODE_W_BUSY   = 4'h3;
    localparam logic [3:0] CODE_W_DONE   = 4'h4;
    localparam logic [3:0] CODE_R_SETTLE = 4'h8;
    localparam logic [3:0] CODE_R_REQ    = 4'h9;
    localparam logic [3:0] CODE_R_BUSY   = 4'hA;
    localparam logic [3:0] CODE_PASS     = 4'hB;
    localparam logic [3:0] CODE_FAIL     = 4'hC;

endpackage

// File: rtl/seq_settle_timer.sv
module seq_settle_timer #(
    parameter int SETTLE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/seq_strobe_qual.sv
module seq_strobe_qual #(
    parameter bit USE_CE = 1'b1,
    parameter int CE_W   = 4,
    parameter int CE_SEL = 0
) (
    input  logic            stb,
    input  logic [CE_W-1:0] ce,
    output logic            hit
);
    generate
        if (USE_CE) begin : g_with_ce
            assign hit = stb & ce[CE_SEL];
        end else begin : g_no_ce
            logic ce_any;
            assign ce_any = |ce;
            assign hit = stb | (ce_any & 1'b0);
        end
    endgenerate
endmodule

// File: rtl/seq_data_path.sv
module seq_data_path #(
    parameter int DW    = 32,
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_wr,
    input  logic [NIB_W-1:0] wr_value,
    input  logic             cap_en,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic [DW-1:0]    cap_word,
    output logic             match
);
    logic [NIB_W-1:0] wr_nib_q;
    logic [DW-1:0]    cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_nib_q <= '0;
            cap_q    <= '0;
        end else begin
            if (load_wr) wr_nib_q <= wr_value;
            if (cap_en)  cap_q    <= din;
        end
    end

    assign dout     = {{(DW-NIB_W){1'b0}}, wr_nib_q};
    assign cap_word = cap_q;
    assign match    = (cap_q[NIB_W-1:0] == wr_nib_q);

    // R6
    cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(cap_q));

endmodule

// File: rtl/bus_loop_seq.sv
module bus_loop_seq
    import bus_loop_pkg::*;
#(
    parameter int          AW          = 32,
    parameter int          DW          = 32,
    parameter int          NIB_W       = 4,
    parameter int          BE_LANES    = 8,
    parameter int          SETTLE_CYC  = 10,
    parameter bit          USE_CE      = 1'b1,
    parameter int          CE_W        = 4,
    parameter int          CE_SEL      = 1,
    parameter logic [31:0] TARGET_ADDR = 32'h8000_0040
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                btn_wr_n,
    input  logic                btn_rd_n,
    input  logic                btn_clr_n,
    input  logic [NIB_W-1:0]    wr_value,
    output logic                mst_rd_req,
    output logic                mst_wr_req,
    output logic [AW-1:0]       mst_addr,
    output logic [BE_LANES-1:0] mst_be,
    input  logic                mst_rd_done,
    input  logic                mst_wr_done,
    input  logic                loc_wr_stb,
    input  logic [CE_W-1:0]     loc_wr_ce,
    input  logic [DW-1:0]       loc_din,
    output logic                loc_wr_ack,
    input  logic                loc_rd_stb,
    input  logic [CE_W-1:0]     loc_rd_ce,
    output logic [DW-1:0]       loc_dout,
    output logic                loc_rd_ack,
    output logic [DW-1:0]       rd_data,
    output logic [3:0]          status
);
    seq_state_t state_q, state_d;

    logic wr_hit, rd_hit, settle_done, cmp_match;
    logic start_wr, start_rd, cap_en;

    assign start_wr = (state_q == ST_IDLE) && !btn_wr_n;
    assign start_rd = (state_q == ST_IDLE) && btn_wr_n && !btn_rd_n;
    assign cap_en   = (state_q == ST_R_REQ) && wr_hit;

    seq_strobe_qual #(.USE_CE(USE_CE), .CE_W(CE_W), .CE_SEL(CE_SEL)) i_wr_qual (
        .stb(loc_wr_stb), .ce(loc_wr_ce), .hit(wr_hit)
    );

    seq_strobe_qual #(.USE_CE(USE_CE), .CE_W(CE_W), .CE_SEL(CE_SEL)) i_rd_qual (
        .stb(loc_rd_stb), .ce(loc_rd_ce), .hit(rd_hit)
    );

    seq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
        .clk(clk), .rst(rst), .load(start_wr | start_rd), .expired(settle_done)
    );

    seq_data_path #(.DW(DW), .NIB_W(NIB_W)) i_data (
        .clk(clk), .rst(rst), .load_wr(start_wr), .wr_value(wr_value),
        .cap_en(cap_en), .din(loc_din), .dout(loc_dout),
        .cap_word(rd_data), .match(cmp_match)
    );

    assign mst_addr = AW'(TARGET_ADDR);
    assign mst_be   = '1;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_d = ST_W_SETTLE;
                else if (start_rd) state_d = ST_R_SETTLE;
            end
            ST_W_SETTLE: if (settle_done) state_d = ST_W_REQ;
            ST_W_REQ:    if (rd_hit)      state_d = ST_W_ACK;
            ST_W_ACK:    state_d = mst_wr_done ? ST_W_DONE : ST_W_WAIT;
            ST_W_WAIT:   if (mst_wr_done) state_d = ST_W_DONE;
            ST_W_DONE:   if (!btn_clr_n)  state_d = ST_IDLE;
            ST_R_SETTLE: if (settle_done) state_d = ST_R_REQ;
            ST_R_REQ:    if (wr_hit)      state_d = ST_R_ACK;
            ST_R_ACK:    state_d = mst_rd_done ? ST_R_DONE : ST_R_WAIT;
            ST_R_WAIT:   if (mst_rd_done) state_d = ST_R_DONE;
            ST_R_DONE:   if (!btn_clr_n)  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        mst_wr_req = 1'b0;
        mst_rd_req = 1'b0;
        loc_rd_ack = 1'b0;
        loc_wr_ack = 1'b0;
        status     = CODE_IDLE;
        unique case (state_q)
            ST_IDLE:     status = CODE_IDLE;
            ST_W_SETTLE: status = CODE_W_SETTLE;
            ST_W_REQ: begin
                mst_wr_req = 1'b1;
                status     = CODE_W_REQ;
            end
            ST_W_ACK: begin
                mst_wr_req = 1'b1;
                loc_rd_ack = 1'b1;
                status     = CODE_W_BUSY;
            end
            ST_W_WAIT: begin
                mst_wr_req = 1'b1;
                status     = CODE_W_BUSY;
            end
            ST_W_DONE:   status = CODE_W_DONE;
            ST_R_SETTLE: status = CODE_R_SETTLE;
            ST_R_REQ: begin
                mst_rd_req = 1'b1;
                status     = CODE_R_REQ;
            end
            ST_R_ACK: begin
                mst_rd_req = 1'b1;
                loc_wr_ack = 1'b1;
                status     = CODE_R_BUSY;
            end
            ST_R_WAIT: begin
                mst_rd_req = 1'b1;
                status     = CODE_R_BUSY;
            end
            ST_R_DONE:   status = cmp_match ? CODE_PASS : CODE_FAIL;
            default:     status = CODE_IDLE;
        endcase
    end

    // R4
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mst_rd_req && mst_wr_req));

    // R4
    wr_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mst_wr_req && !mst_wr_done) |=> mst_wr_req);

    // R7
    rd_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mst_rd_req && !mst_rd_done) |=> mst_rd_req);

    // R3
    rd_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        loc_rd_ack |=> !loc_rd_ack);

    // R6
    wr_ack_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
        loc_wr_ack |-> $past(loc_wr_stb));

    // R2
    wr_req_after_settle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mst_wr_req) |-> $past(settle_done));

    // R9
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_W_DONE && btn_clr_n) |=> (state_q == ST_W_DONE));

endmodule

// File: tb/test_bus_loop_seq.sv
`timescale 1ns/1ps
module test_bus_loop_seq;
    localparam int          AW = 32, DW = 32, NIB_W = 4, BE = 8;
    localparam int          SETTLE = 10, CE_W = 4, CE_SEL = 1;
    localparam logic [31:0] TADDR = 32'h8000_0040;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic btn_wr_n = 1'b1, btn_rd_n = 1'b1, btn_clr_n = 1'b1;
    logic [NIB_W-1:0] wr_value = '0;
    logic mst_rd_req, mst_wr_req, mst_rd_done = 1'b0, mst_wr_done = 1'b0;
    logic [AW-1:0] mst_addr;
    logic [BE-1:0] mst_be;
    logic loc_wr_stb = 1'b0, loc_rd_stb = 1'b0;
    logic [CE_W-1:0] loc_wr_ce = '0, loc_rd_ce = '0;
    logic [DW-1:0] loc_din = '0, loc_dout, rd_data;
    logic loc_wr_ack, loc_rd_ack;
    logic [3:0] status;

    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    bus_loop_seq #(.AW(AW), .DW(DW), .NIB_W(NIB_W), .BE_LANES(BE),
        .SETTLE_CYC(SETTLE), .USE_CE(1'b1), .CE_W(CE_W), .CE_SEL(CE_SEL),
        .TARGET_ADDR(TADDR)) i_bus_loop_seq (
        .clk(clk), .rst(rst), .btn_wr_n(btn_wr_n), .btn_rd_n(btn_rd_n),
        .btn_clr_n(btn_clr_n), .wr_value(wr_value),
        .mst_rd_req(mst_rd_req), .mst_wr_req(mst_wr_req),
        .mst_addr(mst_addr), .mst_be(mst_be),
        .mst_rd_done(mst_rd_done), .mst_wr_done(mst_wr_done),
        .loc_wr_stb(loc_wr_stb), .loc_wr_ce(loc_wr_ce), .loc_din(loc_din),
        .loc_wr_ack(loc_wr_ack), .loc_rd_stb(loc_rd_stb), .loc_rd_ce(loc_rd_ce),
        .loc_dout(loc_dout), .loc_rd_ack(loc_rd_ack), .rd_data(rd_data),
        .status(status)
    );

    // Behavioural reference: phase number and a cycle counter in the settle window
    int phase = 0;
    int waited = 0;
    logic [3:0] m_nib = '0;
    logic [DW-1:0] m_cap = '0;
    bit started = 0;

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            phase <= 0; waited <= 0; m_nib <= '0; m_cap <= '0;
        end else begin
            case (phase)
                0: if (!btn_wr_n) begin m_nib <= wr_value; phase <= 1; waited <= 1; end
                   else if (!btn_rd_n) begin phase <= 6; waited <= 1; end
                1, 6: if (waited == SETTLE) phase <= phase + 1; else waited <= waited + 1;
                2: if (loc_rd_stb && loc_rd_ce[CE_SEL]) phase <= 3;
                3: phase <= mst_wr_done ? 5 : 4;
                4: if (mst_wr_done) phase <= 5;
                7: if (loc_wr_stb && loc_wr_ce[CE_SEL]) begin m_cap <= loc_din; phase <= 8; end
                8: phase <= mst_rd_done ? 10 : 9;
                9: if (mst_rd_done) phase <= 10;
                5, 10: if (!btn_clr_n) phase <= 0;
                default: phase <= 0;
            endcase
        end
    end

    function automatic logic [3:0] exp_status();
        case (phase)
            0: return 4'h0;  1: return 4'h1;  2: return 4'h2;
            3, 4: return 4'h3;  5: return 4'h4;  6: return 4'h8;
            7: return 4'h9;  8, 9: return 4'hA;
            10: return (m_cap[3:0] == m_nib) ? 4'hB : 4'hC;
            default: return 4'hF;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every cycle against the reference
    always @(negedge clk) begin
        if (started) begin
            check("R8 status", 64'(status), 64'(exp_status()));
            check("R4 wr_req", 64'(mst_wr_req), 64'(phase >= 2 && phase <= 4));
            check("R7 rd_req", 64'(mst_rd_req), 64'(phase >= 7 && phase <= 9));
            check("R3 rd_ack", 64'(loc_rd_ack), 64'(phase == 3));
            check("R6 wr_ack", 64'(loc_wr_ack), 64'(phase == 8));
            check("R3 dout", 64'(loc_dout), 64'({28'h0, m_nib}));
            check("R6 rd_data", 64'(rd_data), 64'(m_cap));
            check("R10 addr_be", {mst_addr, 24'h0, mst_be}, {TADDR, 24'h0, 8'hFF});
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic press(int which);
        if (which == 0) btn_wr_n = 1'b0;
        else if (which == 1) btn_rd_n = 1'b0;
        else btn_clr_n = 1'b0;
        tick();
        btn_wr_n = 1'b1; btn_rd_n = 1'b1; btn_clr_n = 1'b1;
    endtask

    task automatic rd_strobe(logic [CE_W-1:0] ce);
        loc_rd_stb = 1'b1; loc_rd_ce = ce; tick();
        loc_rd_stb = 1'b0; loc_rd_ce = '0;
    endtask

    task automatic wr_strobe(logic [CE_W-1:0] ce, logic [DW-1:0] d);
        loc_wr_stb = 1'b1; loc_wr_ce = ce; loc_din = d; tick();
        loc_wr_stb = 1'b0; loc_wr_ce = '0;
    endtask

    task automatic pulse_done(bit is_wr);
        if (is_wr) mst_wr_done = 1'b1; else mst_rd_done = 1'b1;
        tick();
        mst_wr_done = 1'b0; mst_rd_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset status", 64'(status), 64'h0);
        check("R1 reset reqs", 64'({mst_rd_req, mst_wr_req, loc_rd_ack, loc_wr_ack}), 64'h0);
        tick();

        // R2/R3/R4: write 0x5
        wr_value = 4'h5;
        press(0);
        tick(SETTLE + 2);
        rd_strobe(4'b0010);
        tick(3);
        pulse_done(1);
        tick(2);
        @(negedge clk);
        check("R4 write done", 64'(status), 64'h4);
        // R9: start ignored in done state
        tick();
        press(1);
        @(negedge clk);
        check("R9 start ignored", 64'(status), 64'h4);
        tick();
        press(2);
        tick();

        // R5/R6/R7/R8: read that matches
        press(1);
        tick(SETTLE + 2);
        wr_strobe(4'b0010, 32'hABCD_1235);
        tick(2);
        pulse_done(0);
        tick();
        @(negedge clk);
        check("R8 pass code", 64'(status), 64'hB);
        tick();
        press(2);
        tick();

        // R11: wrong chip enable ignored; completion in ack cycle
        wr_value = 4'hA;
        press(0);
        tick(SETTLE + 2);
        rd_strobe(4'b0100);
        @(negedge clk);
        check("R11 ce ignored", 64'({loc_rd_ack, status}), 64'h02);
        tick();
        rd_strobe(4'b0010);
        pulse_done(1);
        @(negedge clk);
        check("R4 done in ack cycle", 64'(status), 64'h4);
        tick();
        press(2);
        tick();

        // R8: mismatching read
        press(1);
        tick(SETTLE + 1);
        wr_strobe(4'b1111, 32'h0000_0013);
        pulse_done(0);
        tick();
        @(negedge clk);
        check("R8 fail code", 64'(status), 64'hC);
        tick();
        press(2);
        tick();

        // R6: strobe while idle ignored
        wr_strobe(4'b0010, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R6 idle strobe ignored", 64'({loc_wr_ack, rd_data}), 64'h13);
        tick();

        // R12: both buttons
        btn_wr_n = 1'b0; btn_rd_n = 1'b0; wr_value = 4'h7;
        tick();
        btn_wr_n = 1'b1; btn_rd_n = 1'b1;
        @(negedge clk);
        check("R12 write wins", 64'(status), 64'h1);
        tick(SETTLE + 2);

        // R1: reset mid-transaction
        rst = 1'b1;
        tick();
        rst = 1'b0;
        @(negedge clk);
        check("R1 mid reset", 64'({mst_wr_req, status}), 64'h0);
        tick(4);
        finish_run();
    end
endmodule